// File: doc/BRIEF.md
# Prioritized interrupt request arbiter

This block arbitrates interrupt requests from up to eight devices. Each device drives a request line together with a 3-bit urgency level. Level 0 is the least urgent and level 7 the most. Every cycle, a comparison tree picks the most urgent pending request. When two or more requests share the top level, the lowest device index wins. The chosen level is then compared with the priority level of the program the processor is running. The interrupt line is raised only when the chosen request is strictly more urgent.

The processor consults the block once per instruction, between the end of one instruction and the fetch of the next, so instructions are never split. It marks that point with a strobe. If the interrupt condition holds on the clock edge where the strobe is high, the block emits a one-cycle take pulse. Each clock edge that sees a pending request also latches the winning device index and its level. The processor can read them to find the device it must serve. When nothing is pending, the latched winner keeps its last value.

Top module: `irq_arbiter`

## Requirements
- R1: After the active-low asynchronous reset, take_o, win_idx_o and win_lvl_o are all zero.
- R2: Among pending requests, the one with the numerically highest level is selected. Device k's level sits at req_lvl_i[3k+2:3k].
- R3: When several pending requests share the highest level, the lowest device index is selected.
- R4: irq_o is high, in the same cycle as its inputs (combinational), exactly when at least one request is pending and the selected level is strictly greater than cur_lvl_i.
- R5: A selected level equal to or below cur_lvl_i keeps irq_o low.
- R6: take_o is high for the single cycle that follows a clock edge at which both boundary_i and the R4 condition held, and is low after any other edge.
- R7: At every clock edge where a request is pending, win_idx_o and win_lvl_o take the index and level of the current selection, visible from the next cycle.
- R8: With no request pending, irq_o is low and win_idx_o and win_lvl_o keep their previous values.
- R9: The level of a device whose request line is low has no effect on the selection, irq_o or take_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_DEV | Request line per device |
| req_lvl_i | input | 3*N_DEV | Packed 3-bit level per device, device k at bits [3k+2:3k] |
| cur_lvl_i | input | 3 | Priority level of the running program |
| boundary_i | input | 1 | Instruction boundary strobe from the processor |
| irq_o | output | 1 | Combinational interrupt condition |
| take_o | output | 1 | One-cycle pulse: interrupt taken at a boundary |
| win_idx_o | output | $clog2(N_DEV) | Registered index of the winning device |
| win_lvl_o | output | 3 | Registered level of the winning device |

## Verification
irq_o is combinational. The bench samples it one nanosecond after driving the inputs on the falling edge, before the next rising edge. take_o, win_idx_o and win_lvl_o are each one register behind their inputs. They are checked one nanosecond after the rising edge that captured the stimulus, against a bench model that updates on that same edge. A full sweep pairs every device level with every running level. Directed tie and masked-level cases follow, then a long pseudo-random sequence in which boundary strobes come and go so that pulse width and hold behaviour are checked across consecutive cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  parameter int unsigned IRQ_LVL_W = 3;
  parameter int unsigned IRQ_N_DEV = 8;

  typedef logic [IRQ_LVL_W-1:0] irq_lvl_t;
endpackage

// File: rtl/irq_prio_tree.sv
module irq_prio_tree
  import irq_pkg::*;
#(
  parameter int unsigned N_DEV = IRQ_N_DEV,
  localparam int unsigned IDX_W = $clog2(N_DEV),
  localparam int unsigned LEAVES = 1 << IDX_W
) (
  input  logic [N_DEV-1:0]           req_i,
  input  logic [N_DEV*IRQ_LVL_W-1:0] req_lvl_i,
  output logic                       win_vld_o,
  output logic [IDX_W-1:0]           win_idx_o,
  output irq_lvl_t                   win_lvl_o
);

  // heap-ordered tree, node 1 is the root, leaves at LEAVES..2*LEAVES-1
  logic                 node_vld [1:2*LEAVES-1];
  irq_lvl_t             node_lvl [1:2*LEAVES-1];
  logic [IDX_W-1:0]     node_idx [1:2*LEAVES-1];

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < N_DEV) begin : g_real
      assign node_vld[LEAVES+k] = req_i[k];
      assign node_lvl[LEAVES+k] = req_lvl_i[k*IRQ_LVL_W +: IRQ_LVL_W];
    end else begin : g_pad
      assign node_vld[LEAVES+k] = 1'b0;
      assign node_lvl[LEAVES+k] = '0;
    end
    assign node_idx[LEAVES+k] = IDX_W'(k);
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_right;
    // strict compare keeps ties on the left (lower index) side
    assign take_right = node_vld[2*n+1] &&
                        (!node_vld[2*n] || (node_lvl[2*n+1] > node_lvl[2*n]));
    assign node_vld[n] = node_vld[2*n] | node_vld[2*n+1];
    assign node_lvl[n] = take_right ? node_lvl[2*n+1] : node_lvl[2*n];
    assign node_idx[n] = take_right ? node_idx[2*n+1] : node_idx[2*n];
  end

  assign win_vld_o = node_vld[1];
  assign win_idx_o = node_idx[1];
  assign win_lvl_o = node_lvl[1];

  always_comb begin
    for (int k = 0; k < N_DEV; k++) begin
      if (req_i[k]) begin
        // R2
        max_lvl_chk: assert (req_lvl_i[k*IRQ_LVL_W +: IRQ_LVL_W] <= win_lvl_o);
        // R3
        tie_low_chk: assert (req_lvl_i[k*IRQ_LVL_W +: IRQ_LVL_W] != win_lvl_o ||
                             k >= int'(win_idx_o));
      end
    end
    if (win_vld_o) begin
      // R2
      win_req_chk: assert (req_i[win_idx_o]);
    end
  end

endmodule

// File: rtl/irq_lvl_gate.sv
module irq_lvl_gate
  import irq_pkg::*;
(
  input  logic     win_vld_i,
  input  irq_lvl_t win_lvl_i,
  input  irq_lvl_t cur_lvl_i,
  output logic     irq_o
);

  assign irq_o = win_vld_i && (win_lvl_i > cur_lvl_i);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int unsigned N_DEV = IRQ_N_DEV,
  localparam int unsigned IDX_W = $clog2(N_DEV)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_DEV-1:0]           req_i,
  input  logic [N_DEV*IRQ_LVL_W-1:0] req_lvl_i,
  input  logic [IRQ_LVL_W-1:0]       cur_lvl_i,
  input  logic                       boundary_i,
  output logic                       irq_o,
  output logic                       take_o,
  output logic [IDX_W-1:0]           win_idx_o,
  output logic [IRQ_LVL_W-1:0]       win_lvl_o
);

  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  irq_lvl_t         win_lvl;
  logic             irq_cond;

  logic             take_q;
  logic [IDX_W-1:0] idx_q;
  irq_lvl_t         lvl_q;

  irq_prio_tree #(.N_DEV(N_DEV)) u_tree (
    .req_i     (req_i),
    .req_lvl_i (req_lvl_i),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  irq_lvl_gate u_gate (
    .win_vld_i (win_vld),
    .win_lvl_i (win_lvl),
    .cur_lvl_i (cur_lvl_i),
    .irq_o     (irq_cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_q <= 1'b0;
      idx_q  <= '0;
      lvl_q  <= '0;
    end else begin
      take_q <= boundary_i & irq_cond;
      if (win_vld) begin
        idx_q <= win_idx;
        lvl_q <= win_lvl;
      end
    end
  end

  assign irq_o     = irq_cond;
  assign take_o    = take_q;
  assign win_idx_o = idx_q;
  assign win_lvl_o = lvl_q;

  // R4
  irq_needs_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|req_i));

  // R5
  irq_above_cur_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_vld && (win_lvl <= cur_lvl_i)) |-> !irq_o);

  // R6
  take_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> $past(boundary_i && irq_o));

  // R6
  take_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(boundary_i && irq_o) |=> !take_o);

  // R7
  latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_vld |=> (win_idx_o == $past(win_idx)) && (win_lvl_o == $past(win_lvl)));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|req_i) |=> $stable(win_idx_o) && $stable(win_lvl_o));

endmodule

// File: tb/irq_arbiter_bench.sv
`timescale 1ns/1ps
module irq_arbiter_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [3*N-1:0] lvls = '0;
  logic [2:0]    cur = '0;
  logic          bnd = 1'b0;
  logic          irq;
  logic          take;
  logic [IW-1:0] widx;
  logic [2:0]    wlvl;

  int n_chk = 0;
  int n_fail = 0;
  int m_idx = 0;
  int m_lvl = 0;
  bit done = 1'b0;
  logic [31:0] rng = 32'h1bad_5eed;

  always #2 clk = ~clk;

  irq_arbiter u_irq_arbiter (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .req_lvl_i  (lvls),
    .cur_lvl_i  (cur),
    .boundary_i (bnd),
    .irq_o      (irq),
    .take_o     (take),
    .win_idx_o  (widx),
    .win_lvl_o  (wlvl)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  // drive on falling edge, check comb output, then registered outputs after rise
  task automatic apply(input logic [N-1:0] r, input logic [3*N-1:0] l,
                       input logic [2:0] c, input logic b, input string tag);
    int best_i;
    int best_l;
    bit any;
    bit exp_irq;
    @(negedge clk);
    req = r; lvls = l; cur = c; bnd = b;
    any = 0; best_i = 0; best_l = 0;
    for (int k = 0; k < N; k++) begin
      if (r[k] && (!any || int'(l[3*k +: 3]) > best_l)) begin
        any = 1; best_i = k; best_l = int'(l[3*k +: 3]);
      end
    end
    exp_irq = any && (best_l > int'(c));
    #1;
    chk(irq == exp_irq, {tag, " R4/R5 irq_o"}, int'(irq), int'(exp_irq));
    if (!any) chk(irq == 1'b0, {tag, " R8 irq_o idle"}, int'(irq), 0);
    if (any) begin m_idx = best_i; m_lvl = best_l; end
    @(posedge clk);
    #1;
    chk(take == (b && exp_irq), {tag, " R6 take_o"}, int'(take), int'(b && exp_irq));
    chk(int'(widx) == m_idx, {tag, " R2/R3/R7/R8 win_idx_o"}, int'(widx), m_idx);
    chk(int'(wlvl) == m_lvl, {tag, " R2/R7/R8 win_lvl_o"}, int'(wlvl), m_lvl);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [3*N-1:0] l;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(take == 1'b0, "R1 take_o reset", int'(take), 0);
    chk(widx == '0, "R1 win_idx_o reset", int'(widx), 0);
    chk(wlvl == '0, "R1 win_lvl_o reset", int'(wlvl), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: idle after reset
    apply('0, {N{3'd7}}, 3'd0, 1'b1, "R8 idle");

    // R4 R5: every device level against every running level on device 5
    for (int c = 0; c < 8; c++) begin
      for (int v = 0; v < 8; v++) begin
        l = '0;
        l[15 +: 3] = 3'(v);
        apply(8'b0010_0000, l, 3'(c), 1'b1, "R4 sweep");
        apply(8'b0010_0000, l, 3'(c), 1'b0, "R6 no strobe");
      end
    end

    // R3: all equal, lowest index
    apply(8'hFF, {N{3'd4}}, 3'd2, 1'b1, "R3 all tie");
    // R3: devices 3 and 6 tie at 6 above others
    l = {N{3'd1}};
    l[9 +: 3] = 3'd6; l[18 +: 3] = 3'd6;
    apply(8'b0100_1010, l, 3'd0, 1'b1, "R3 pair tie");
    // R9: masked device with level 7 ignored
    l = '0;
    l[21 +: 3] = 3'd7; l[6 +: 3] = 3'd3;
    apply(8'b0000_0100, l, 3'd3, 1'b1, "R9 masked");
    apply(8'b0000_0100, l, 3'd2, 1'b1, "R9 masked hi");
    // R8: hold after requests vanish
    apply('0, {N{3'd5}}, 3'd0, 1'b1, "R8 hold");
    apply('0, '0, 3'd0, 1'b0, "R8 hold2");

    // R2 R6 R7: pseudo-random sequence
    for (int i = 0; i < 3000; i++) begin
      logic [N-1:0] r;
      rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
      r = rng[7:0] & rng[15:8];
      if (rng[31:29] == 3'd0) r = '0;
      l = {rng[23:0] ^ {rng[7:0], rng[31:16]}};
      apply(r, l, rng[26:24], rng[27], "R2 random");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule